// File: doc/BRIEF.md
# Dual-Channel Segmented Converter Switch Decoder

This block is the digital front end of a two-channel, 8-bit current-steering converter. Each channel (I and Q) takes an offset-binary code and registers it on the rising clock edge. It then splits the code into two parts. The five upper bits become a thermometer of 31 equal-weight segment enables. The three lower bits drive binary-weighted switches directly. Each switch group is produced twice: a true vector, which steers current to the positive output, and its bitwise complement, which steers it to the negative output.

The path has two register stages. A code presented before one rising edge reaches the switch controls after the next edge, so the latency is one full clock period. One sleep input is shared by both channels. While it is high, every switch enable on both sides is forced off and the pipeline freezes. For checking, each channel also reports the current its switches would draw, in LSB units. This value is recomputed from the switch vectors themselves.

Top module: `dacseg_top`

## Requirements
- R1: The input code is 8 bits of offset binary, with bit 7 the most significant bit. It is sampled only on the rising clock edge.
- R2: If the upper five bits hold the value k, exactly the lowest k of the 31 true segment enables are set (bit 0 first) and all other segment enables are clear.
- R3: True binary enable bit i (i = 0..2) equals bit i of the code and carries a weight of 2^i LSB. Each segment carries a weight of 8 LSB.
- R4: When awake, the complementary segment vector and the complementary binary vector are the bitwise inverses of the true vectors.
- R5: A code sampled at one rising edge drives the switch outputs from the following rising edge onward. This is a latency of one clock period.
- R6: When awake, the true level equals the code and the complementary level equals 255 minus the code. Code 255 gives 255/0 and code 0 gives 0/255.
- R7: Mid-scale code 128 sets 16 segments and no binary switches. This gives a true level of 128 and a complementary level of 127, one LSB apart.
- R8: The I and Q channels share the clock, reset and sleep input but carry independent codes. Different codes on the two channels never disturb each other.
- R9: A sleep input sampled high forces every true and complementary enable of both channels to zero, and both levels to zero, from that edge onward.
- R10: While sleep is sampled high, neither register stage changes. At the first edge with sleep low, the output shows the code held in the first stage, and the first stage captures the present input.
- R11: A synchronous active-high reset clears both stages of both channels to code 0 and clears the sleep state. After reset the true vectors are all zero and the complementary vectors are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sleep | input | 1 | Shared power-down request, active high |
| i_code | input | 8 | I-channel offset-binary code |
| q_code | input | 8 | Q-channel offset-binary code |
| i_seg_on | output | 31 | I true segment enables |
| i_seg_off | output | 31 | I complementary segment enables |
| i_lsb_on | output | 3 | I true binary enables |
| i_lsb_off | output | 3 | I complementary binary enables |
| i_level | output | 8 | I true-side current model, LSB units |
| i_level_n | output | 8 | I complementary-side current model, LSB units |
| q_seg_on | output | 31 | Q true segment enables |
| q_seg_off | output | 31 | Q complementary segment enables |
| q_lsb_on | output | 3 | Q true binary enables |
| q_lsb_off | output | 3 | Q complementary binary enables |
| q_level | output | 8 | Q true-side current model, LSB units |
| q_level_n | output | 8 | Q complementary-side current model, LSB units |

## Verification
The latency and sum properties assume that the codes and the sleep input are known and stable around each rising edge. They also assume that reset has been held low for at least two edges before a code is compared with its delayed image. The stimulus changes every input only on the falling edge. It raises reset at time zero and releases it before any comparison. Sleep episodes are placed between runs of ordinary codes, so that the freeze, wake and delayed-code relations are each exercised while their preconditions hold.

// File: rtl/dacseg_pkg.sv
package dacseg_pkg;
  localparam int CODE_W = 8;
  localparam int LOW_W  = 3;
  localparam int HIGH_W = CODE_W - LOW_W;
  localparam int SEG_N  = (1 << HIGH_W) - 1;
  localparam int SEG_WT = 1 << LOW_W;
  localparam int FULL   = (1 << CODE_W) - 1;
  localparam int CH_N   = 2;
endpackage

// File: rtl/dacseg_capture.sv
module dacseg_capture #(
  parameter int W = dacseg_pkg::CODE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (!hold) q <= d;
  end
endmodule

// File: rtl/dacseg_decoder.sv
module dacseg_decoder #(
  parameter int CODE_W = dacseg_pkg::CODE_W,
  parameter int LOW_W  = dacseg_pkg::LOW_W,
  localparam int HIGH_W = CODE_W - LOW_W,
  localparam int SEG_N  = (1 << HIGH_W) - 1
) (
  input  logic [CODE_W-1:0] code,
  output logic [SEG_N-1:0]  seg,
  output logic [LOW_W-1:0]  lsb
);
  logic [HIGH_W-1:0] upper;
  assign upper = code[CODE_W-1:LOW_W];
  assign lsb   = code[LOW_W-1:0];

  for (genvar g = 0; g < SEG_N; g++) begin : g_therm
    assign seg[g] = (upper > HIGH_W'(g));
  end
endmodule

// File: rtl/dacseg_current.sv
module dacseg_current #(
  parameter int CODE_W = dacseg_pkg::CODE_W,
  parameter int LOW_W  = dacseg_pkg::LOW_W,
  localparam int SEG_N  = (1 << (CODE_W - LOW_W)) - 1,
  localparam int SEG_WT = 1 << LOW_W
) (
  input  logic [SEG_N-1:0]  seg,
  input  logic [LOW_W-1:0]  lsb,
  output logic [CODE_W-1:0] level
);
  int cnt;
  always_comb begin
    cnt = 0;
    for (int i = 0; i < SEG_N; i++) cnt = cnt + int'(seg[i]);
    level = CODE_W'(cnt * SEG_WT + int'(lsb));
  end
endmodule

// File: rtl/dacseg_lane.sv
module dacseg_lane #(
  parameter int CODE_W = dacseg_pkg::CODE_W,
  parameter int LOW_W  = dacseg_pkg::LOW_W,
  localparam int SEG_N  = (1 << (CODE_W - LOW_W)) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              asleep,
  input  logic [CODE_W-1:0] code,
  output logic [SEG_N-1:0]  seg_on,
  output logic [SEG_N-1:0]  seg_off,
  output logic [LOW_W-1:0]  lsb_on,
  output logic [LOW_W-1:0]  lsb_off
);
  logic [CODE_W-1:0] stage1;
  logic [SEG_N-1:0]  seg_d, seg_r;
  logic [LOW_W-1:0]  lsb_d, lsb_r;

  dacseg_capture #(.W(CODE_W)) u_cap (
    .clk(clk), .rst(rst), .hold(hold), .d(code), .q(stage1)
  );

  dacseg_decoder #(.CODE_W(CODE_W), .LOW_W(LOW_W)) u_dec (
    .code(stage1), .seg(seg_d), .lsb(lsb_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_r <= '0;
      lsb_r <= '0;
    end else if (!hold) begin
      seg_r <= seg_d;
      lsb_r <= lsb_d;
    end
  end

  assign seg_on  = asleep ? '0 : seg_r;
  assign seg_off = asleep ? '0 : ~seg_r;
  assign lsb_on  = asleep ? '0 : lsb_r;
  assign lsb_off = asleep ? '0 : ~lsb_r;

  // R2
  thermo_shape_chk: assert property (@(posedge clk) disable iff (rst)
    ((seg_on & (seg_on + 1'b1)) == '0));

  // R4
  comp_inverse_chk: assert property (@(posedge clk) disable iff (rst)
    !asleep |-> (seg_off == ~seg_on) && (lsb_off == ~lsb_on));

  // R9
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    asleep |-> (seg_on == '0) && (seg_off == '0) && (lsb_on == '0) && (lsb_off == '0));

  // R10
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(hold) && !$past(rst)) |-> ($stable(seg_r) && $stable(stage1)));
endmodule

// File: rtl/dacseg_top.sv
module dacseg_top #(
  parameter int CODE_W = dacseg_pkg::CODE_W,
  parameter int LOW_W  = dacseg_pkg::LOW_W,
  localparam int SEG_N  = (1 << (CODE_W - LOW_W)) - 1,
  localparam int FULL   = (1 << CODE_W) - 1,
  localparam int CH_N   = dacseg_pkg::CH_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep,
  input  logic [CODE_W-1:0] i_code,
  input  logic [CODE_W-1:0] q_code,
  output logic [SEG_N-1:0]  i_seg_on,
  output logic [SEG_N-1:0]  i_seg_off,
  output logic [LOW_W-1:0]  i_lsb_on,
  output logic [LOW_W-1:0]  i_lsb_off,
  output logic [CODE_W-1:0] i_level,
  output logic [CODE_W-1:0] i_level_n,
  output logic [SEG_N-1:0]  q_seg_on,
  output logic [SEG_N-1:0]  q_seg_off,
  output logic [LOW_W-1:0]  q_lsb_on,
  output logic [LOW_W-1:0]  q_lsb_off,
  output logic [CODE_W-1:0] q_level,
  output logic [CODE_W-1:0] q_level_n
);
  logic asleep;
  logic [CH_N-1:0][CODE_W-1:0] code_v;
  logic [CH_N-1:0][SEG_N-1:0]  son_v, soff_v;
  logic [CH_N-1:0][LOW_W-1:0]  lon_v, loff_v;
  logic [CH_N-1:0][CODE_W-1:0] lvl_v, lvln_v;

  always_ff @(posedge clk) begin
    if (rst) asleep <= 1'b0;
    else     asleep <= sleep;
  end

  assign code_v[0] = i_code;
  assign code_v[1] = q_code;

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    dacseg_lane #(.CODE_W(CODE_W), .LOW_W(LOW_W)) u_lane (
      .clk(clk), .rst(rst), .hold(sleep), .asleep(asleep), .code(code_v[c]),
      .seg_on(son_v[c]), .seg_off(soff_v[c]), .lsb_on(lon_v[c]), .lsb_off(loff_v[c])
    );
    dacseg_current #(.CODE_W(CODE_W), .LOW_W(LOW_W)) u_pos (
      .seg(son_v[c]), .lsb(lon_v[c]), .level(lvl_v[c])
    );
    dacseg_current #(.CODE_W(CODE_W), .LOW_W(LOW_W)) u_neg (
      .seg(soff_v[c]), .lsb(loff_v[c]), .level(lvln_v[c])
    );
  end

  assign i_seg_on  = son_v[0];
  assign i_seg_off = soff_v[0];
  assign i_lsb_on  = lon_v[0];
  assign i_lsb_off = loff_v[0];
  assign i_level   = lvl_v[0];
  assign i_level_n = lvln_v[0];
  assign q_seg_on  = son_v[1];
  assign q_seg_off = soff_v[1];
  assign q_lsb_on  = lon_v[1];
  assign q_lsb_off = loff_v[1];
  assign q_level   = lvl_v[1];
  assign q_level_n = lvln_v[1];

  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst)              warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R6
  sum_full_chk: assert property (@(posedge clk) disable iff (rst)
    !asleep |-> ((int'(i_level) + int'(i_level_n)) == FULL) &&
                ((int'(q_level) + int'(q_level_n)) == FULL));

  // R5
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd2 && !$past(sleep) && !$past(sleep, 2)) |->
      (i_level == $past(i_code, 2)) && (q_level == $past(q_code, 2)));

  // R9
  sleep_level_chk: assert property (@(posedge clk) disable iff (rst)
    asleep |-> (i_level == '0) && (q_level == '0) && (i_level_n == '0) && (q_level_n == '0));
endmodule

// File: tb/tb_dacseg_top.sv
module tb_dacseg_top;
  localparam int CODE_W = 8;
  localparam int LOW_W  = 3;
  localparam int SEG_N  = 31;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep = 1'b0;
  logic [7:0] i_code = 8'd0, q_code = 8'd0;
  logic [SEG_N-1:0] i_seg_on, i_seg_off, q_seg_on, q_seg_off;
  logic [2:0] i_lsb_on, i_lsb_off, q_lsb_on, q_lsb_off;
  logic [7:0] i_level, i_level_n, q_level, q_level_n;

  always #2.5 clk = ~clk;

  dacseg_top dut (
    .clk(clk), .rst(rst), .sleep(sleep), .i_code(i_code), .q_code(q_code),
    .i_seg_on(i_seg_on), .i_seg_off(i_seg_off), .i_lsb_on(i_lsb_on), .i_lsb_off(i_lsb_off),
    .i_level(i_level), .i_level_n(i_level_n),
    .q_seg_on(q_seg_on), .q_seg_off(q_seg_off), .q_lsb_on(q_lsb_on), .q_lsb_off(q_lsb_off),
    .q_level(q_level), .q_level_n(q_level_n)
  );

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  string phase = "R11";

  // behavioural reference: two stages per channel and a sleep flag
  int m1 [2];
  int m2 [2];
  bit msleep;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      m1[0] <= 0; m1[1] <= 0; m2[0] <= 0; m2[1] <= 0; msleep <= 1'b0;
    end else begin
      msleep <= sleep;
      if (!sleep) begin
        m2[0] <= m1[0]; m2[1] <= m1[1];
        m1[0] <= int'(i_code); m1[1] <= int'(q_code);
      end
    end
  end

  task automatic chk(input string tag, input string what, input int ch,
                     input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s/%s %s ch%0d: got %h expected %h", phase, tag, what, ch, got, exp);
    end
  endtask

  task automatic compare();
    for (int ch = 0; ch < 2; ch++) begin
      logic [63:0] eseg, elsb, esegn, elsbn, elvl, elvln;
      logic [63:0] aseg, alsb, asegn, alsbn, alvl, alvln;
      int code = m2[ch];
      eseg  = (64'd1 << (code >> 3)) - 64'd1;
      elsb  = 64'(code & 7);
      esegn = ~eseg & ((64'd1 << SEG_N) - 64'd1);
      elsbn = ~elsb & 64'd7;
      elvl  = 64'(code);
      elvln = 64'(255 - code);
      if (msleep) begin
        eseg = '0; elsb = '0; esegn = '0; elsbn = '0; elvl = '0; elvln = '0;
      end
      aseg  = 64'(ch == 0 ? i_seg_on  : q_seg_on);
      asegn = 64'(ch == 0 ? i_seg_off : q_seg_off);
      alsb  = 64'(ch == 0 ? i_lsb_on  : q_lsb_on);
      alsbn = 64'(ch == 0 ? i_lsb_off : q_lsb_off);
      alvl  = 64'(ch == 0 ? i_level   : q_level);
      alvln = 64'(ch == 0 ? i_level_n : q_level_n);
      chk("R2", "seg_on", ch, aseg, eseg);
      chk("R3", "lsb_on", ch, alsb, elsb);
      chk("R4", "seg_off", ch, asegn, esegn);
      chk("R4", "lsb_off", ch, alsbn, elsbn);
      chk("R6", "level", ch, alvl, elvl);
      chk("R6", "level_n", ch, alvln, elvln);
    end
  endtask

  task automatic step(input logic [7:0] ic, input logic [7:0] qc, input logic s);
    @(negedge clk);
    compare();
    i_code = ic; q_code = qc; sleep = s;
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state at the ports
    phase = "R11";
    compare();
    rst = 1'b0;
    step(8'd0, 8'd0, 1'b0);
    step(8'd0, 8'd0, 1'b0);

    // R6: full-scale ends, R7: mid-scale, R5: one-period latency
    phase = "R6";
    step(8'd255, 8'd0, 1'b0);
    step(8'd0, 8'd255, 1'b0);
    phase = "R7";
    step(8'd128, 8'd128, 1'b0);
    step(8'd127, 8'd129, 1'b0);
    phase = "R5";
    step(8'd8, 8'd7, 1'b0);
    step(8'd7, 8'd8, 1'b0);
    step(8'd7, 8'd8, 1'b0);
    step(8'd7, 8'd8, 1'b0);

    // R2 / R3 / R8: full sweep with opposing codes per channel
    phase = "R8";
    for (int v = 0; v < 256; v++) step(8'(v), 8'(255 - v), 1'b0);

    // R9 / R10: sleep episodes with changing inputs during sleep
    phase = "R9";
    step(8'd200, 8'd33, 1'b0);
    step(8'd201, 8'd34, 1'b0);
    step(8'd90, 8'd91, 1'b1);
    step(8'd11, 8'd12, 1'b1);
    step(8'd13, 8'd14, 1'b1);
    phase = "R10";
    step(8'd60, 8'd61, 1'b0);
    step(8'd62, 8'd63, 1'b0);
    step(8'd64, 8'd65, 1'b0);
    step(8'd66, 8'd67, 1'b1);
    step(8'd68, 8'd69, 1'b0);
    step(8'd70, 8'd71, 1'b0);
    step(8'd72, 8'd73, 1'b0);

    // R1: pseudo-random traffic with sparse sleep
    phase = "R1";
    for (int n = 0; n < 300; n++)
      step(8'($urandom), 8'($urandom), ($urandom % 16) == 0);
    step(8'd0, 8'd0, 1'b0);
    step(8'd0, 8'd0, 1'b0);
    step(8'd0, 8'd0, 1'b0);

    // R11: reset in mid-traffic returns to code zero
    phase = "R11";
    step(8'd250, 8'd5, 1'b0);
    step(8'd250, 8'd5, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    step(8'd99, 8'd98, 1'b0);
    step(8'd99, 8'd98, 1'b0);
    rst = 1'b0;
    step(8'd99, 8'd98, 1'b0);
    step(8'd99, 8'd98, 1'b0);
    step(8'd99, 8'd98, 1'b0);
    done = 1'b1;
  end

  initial begin
    while (!done && cycles < 100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule